// File: doc/BRIEF.md
# Receive Sampling Tap Auto-Tuner

This block picks the receive sampling delay for a high-speed SD or eMMC data path. A controller pulses `start_i`. The tuner first turns on the input tap delay. It then steps the tap select through every position in ascending order. At each position it asks an external tuning agent for one pass or fail verdict. The agent sends the tuning command and reports whether the data came back intact.

From the verdicts the tuner finds where the last passing window begins, and counts how many taps failed. It treats the tap range as a ring and parks the tap in the middle of the passing window. It then raises `done_o` for one cycle.

Every change of the tap select, including the final one, is bracketed by a change-window strobe. This lets the delay line take the new code without glitching.

Top module: `itap_autotune`

## Requirements
- R1: After reset, `tap_en_o`, `chg_win_o`, `tap_sel_o`, `res_ready_o` and `done_o` are all 0.
- R2: A `start_i` sampled high while idle sets `tap_en_o` on the next edge. This happens one cycle before the first change-window strobe. `tap_en_o` then stays high until reset.
- R3: The sweep writes taps 0, 1, ..., 31 in that order, one tap per accepted verdict. A verdict is accepted on an edge where `res_ready_o` and `res_valid_i` are both high, and `res_pass_i` = 1 means pass.
- R4: Every tap write follows the same three steps. First `chg_win_o` rises. On the next edge `tap_sel_o` takes the new code. On the edge after that `chg_win_o` falls. `tap_sel_o` never changes unless `chg_win_o` was high in both the cycle before and the cycle of the change.
- R5: The previous verdict starts as pass. The window start is the last tap that passed right after a failing tap, and it stays 0 if there is no such tap. Every failing tap adds one to the fail count.
- R6: The final tap is (window start + (32 − fails) / 2) mod 32, using integer division. If all taps pass the result is 16. If all taps fail the result is 0.
- R7: The final tap is written with the R4 sequence. `done_o` is high for exactly the one cycle after `chg_win_o` falls, and `chg_win_o` is low while `done_o` is high.
- R8: `res_ready_o` is high only between tap writes. It stays high with `tap_sel_o` held for as long as `res_valid_i` stays low, with no time limit.
- R9: `start_i` has no effect while a sweep is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a tuning run (sampled while idle) |
| res_ready_o | output | 1 | Tuner is waiting for a verdict on the current tap |
| res_valid_i | input | 1 | Verdict present from the tuning agent |
| res_pass_i | input | 1 | Verdict value, 1 = pass |
| tap_en_o | output | 1 | Input tap delay enable |
| chg_win_o | output | 1 | Change-window strobe guarding tap updates |
| tap_sel_o | output | TAP_W | Tap select code |
| done_o | output | 1 | One-cycle pulse after the final tap is written |

## Verification
The bound checker watches the write protocol on every cycle. It checks that the tap select moves only inside a change window that was already open one cycle earlier. It also checks that the strobe implies the enable, that the tap stays still while a verdict is pending, that `done_o` lasts one cycle, and that ready and the strobe never overlap.

Other behaviour can only be shown by the bench's scenarios. These are the ascending sweep order, the choice of the last fail-to-pass transition, the mod-32 centre for windows that wrap, the all-pass and all-fail cases, slow verdicts, and a start pulse during a run. The bench checks them with a cycle-accurate reference and with the known final tap for each pattern.

// File: rtl/itap_pkg.sv
package itap_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE   = 2'd0,
    CTL_ENABLE = 2'd1,
    CTL_WRITE  = 2'd2,
    CTL_WAIT   = 2'd3
  } ctl_state_e;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_APPLY = 2'd1,
    WR_CLOSE = 2'd2
  } wr_state_e;
endpackage

// File: rtl/itap_window_tracker.sv
module itap_window_tracker #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W-1:0] centre_o
);
  localparam int NUM_TAPS = 1 << TAP_W;
  localparam logic [TAP_W:0] NUM_V = NUM_TAPS[TAP_W:0];

  logic             prev_q, prev_d;
  logic [TAP_W-1:0] start_q, start_d;
  logic [TAP_W:0]   fails_q, fails_d;
  logic [TAP_W:0]   len;
  logic [TAP_W:0]   sum;

  // statistics including the verdict now being presented
  always_comb begin
    start_d = (pass_i && !prev_q) ? tap_i : start_q;
    fails_d = fails_q + {{TAP_W{1'b0}}, ~pass_i};
    len     = NUM_V - fails_d;
    sum     = {1'b0, start_d} + {1'b0, len[TAP_W:1]};
    centre_o = sum[TAP_W-1:0];
    prev_d  = pass_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      start_q <= '0;
      fails_q <= '0;
    end else if (clr_i) begin
      prev_q  <= 1'b1;
      start_q <= '0;
      fails_q <= '0;
    end else if (upd_i) begin
      prev_q  <= prev_d;
      start_q <= start_d;
      fails_q <= fails_d;
    end
  end
endmodule

// File: rtl/itap_guard_writer.sv
module itap_guard_writer
  import itap_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [TAP_W-1:0] tgt_i,
  output logic             chg_win_o,
  output logic [TAP_W-1:0] tap_sel_o,
  output logic             wr_done_o
);
  wr_state_e        wst_q, wst_d;
  logic             win_q, win_d;
  logic [TAP_W-1:0] sel_q, sel_d;
  logic [TAP_W-1:0] hold_q, hold_d;

  always_comb begin
    wst_d  = wst_q;
    win_d  = win_q;
    sel_d  = sel_q;
    hold_d = hold_q;
    unique case (wst_q)
      WR_IDLE: if (go_i) begin
        win_d  = 1'b1;
        hold_d = tgt_i;
        wst_d  = WR_APPLY;
      end
      WR_APPLY: begin
        sel_d = hold_q;
        wst_d = WR_CLOSE;
      end
      WR_CLOSE: begin
        win_d = 1'b0;
        wst_d = WR_IDLE;
      end
      default: wst_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst_q  <= WR_IDLE;
      win_q  <= 1'b0;
      sel_q  <= '0;
      hold_q <= '0;
    end else begin
      wst_q  <= wst_d;
      win_q  <= win_d;
      sel_q  <= sel_d;
      hold_q <= hold_d;
    end
  end

  assign chg_win_o = win_q;
  assign tap_sel_o = sel_q;
  assign wr_done_o = (wst_q == WR_CLOSE);
endmodule

// File: rtl/itap_autotune.sv
module itap_autotune
  import itap_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             res_ready_o,
  input  logic             res_valid_i,
  input  logic             res_pass_i,
  output logic             tap_en_o,
  output logic             chg_win_o,
  output logic [TAP_W-1:0] tap_sel_o,
  output logic             done_o
);
  localparam logic [TAP_W-1:0] LAST_TAP = {TAP_W{1'b1}};

  ctl_state_e       st_q, st_d;
  logic [TAP_W-1:0] cur_q, cur_d;
  logic             last_q, last_d;
  logic             en_q, en_d;
  logic             done_q, done_d;
  logic             go, clr, upd, wr_done;
  logic [TAP_W-1:0] tgt, centre;

  itap_window_tracker #(.TAP_W(TAP_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .upd_i    (upd),
    .pass_i   (res_pass_i),
    .tap_i    (cur_q),
    .centre_o (centre)
  );

  itap_guard_writer #(.TAP_W(TAP_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .tgt_i     (tgt),
    .chg_win_o (chg_win_o),
    .tap_sel_o (tap_sel_o),
    .wr_done_o (wr_done)
  );

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    last_d = last_q;
    en_d   = en_q;
    done_d = 1'b0;
    go     = 1'b0;
    tgt    = '0;
    clr    = 1'b0;
    upd    = 1'b0;
    unique case (st_q)
      CTL_IDLE: if (start_i) begin
        st_d   = CTL_ENABLE;
        en_d   = 1'b1;
        cur_d  = '0;
        last_d = 1'b0;
        clr    = 1'b1;
      end
      CTL_ENABLE: begin
        go   = 1'b1;
        st_d = CTL_WRITE;
      end
      CTL_WRITE: if (wr_done) begin
        if (last_q) begin
          done_d = 1'b1;
          st_d   = CTL_IDLE;
        end else begin
          st_d = CTL_WAIT;
        end
      end
      CTL_WAIT: if (res_valid_i) begin
        upd = 1'b1;
        go  = 1'b1;
        if (cur_q == LAST_TAP) begin
          tgt    = centre;
          last_d = 1'b1;
        end else begin
          tgt = cur_q + 1'b1;
        end
        cur_d = tgt;
        st_d  = CTL_WRITE;
      end
      default: st_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CTL_IDLE;
      cur_q  <= '0;
      last_q <= 1'b0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      last_q <= last_d;
      en_q   <= en_d;
      done_q <= done_d;
    end
  end

  assign res_ready_o = (st_q == CTL_WAIT);
  assign tap_en_o    = en_q;
  assign done_o      = done_q;
endmodule

module itap_autotune_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_ready_o,
  input logic             res_valid_i,
  input logic             tap_en_o,
  input logic             chg_win_o,
  input logic [TAP_W-1:0] tap_sel_o,
  input logic             done_o
);
  // R4
  guarded_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_sel_o) |-> (chg_win_o && $past(chg_win_o)));
  // R2
  win_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_win_o |-> tap_en_o);
  // R8
  hold_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready_o && !res_valid_i) |=> (res_ready_o && $stable(tap_sel_o)));
  // R8
  ready_no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready_o |-> !chg_win_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!chg_win_o && $past(chg_win_o)));
endmodule

bind itap_autotune itap_autotune_chk #(.TAP_W(TAP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .res_ready_o (res_ready_o),
  .res_valid_i (res_valid_i),
  .tap_en_o    (tap_en_o),
  .chg_win_o   (chg_win_o),
  .tap_sel_o   (tap_sel_o),
  .done_o      (done_o)
);

// File: tb/test_itap_autotune.sv
module test_itap_autotune;
  localparam int TAP_W = 5;
  localparam int NT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic res_valid_i = 1'b0;
  logic res_pass_i = 1'b0;
  logic res_ready_o, tap_en_o, chg_win_o, done_o;
  logic [TAP_W-1:0] tap_sel_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit armed = 0;

  always #2 clk = ~clk;

  itap_autotune #(.TAP_W(TAP_W)) i_itap_autotune (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .res_ready_o(res_ready_o), .res_valid_i(res_valid_i), .res_pass_i(res_pass_i),
    .tap_en_o(tap_en_o), .chg_win_o(chg_win_o), .tap_sel_o(tap_sel_o), .done_o(done_o)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference: mode 0 idle, 1 enabling, 2 writing, 3 waiting
  int m_mode = 0, m_step = 0, m_tgt = 0, m_cur = 0;
  bit m_final = 0;
  bit res_q[$];
  int e_en = 0, e_win = 0, e_sel = 0, e_done = 0, e_rdy = 0;

  function automatic int centre_of(bit q[$]);
    int prev = 1, ps = 0, fails = 0;
    for (int i = 0; i < q.size(); i++) begin
      if (q[i] && !prev) ps = i;
      if (!q[i]) fails++;
      prev = q[i];
    end
    return (ps + (NT - fails) / 2) % NT;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_tgt = 0; m_cur = 0; m_final = 0;
      e_en = 0; e_win = 0; e_sel = 0; e_done = 0;
      res_q.delete();
    end else begin
      e_done = 0;
      case (m_mode)
        0: if (start_i) begin
          e_en = 1; m_mode = 1; m_final = 0; m_cur = 0; res_q.delete();
        end
        1: begin e_win = 1; m_tgt = 0; m_step = 1; m_mode = 2; end
        2: if (m_step == 1) begin
          e_sel = m_tgt; m_step = 2;
        end else begin
          e_win = 0;
          if (m_final) begin e_done = 1; m_mode = 0; end
          else m_mode = 3;
        end
        default: if (res_valid_i) begin
          res_q.push_back(res_pass_i);
          if (res_q.size() == NT) begin
            m_tgt = centre_of(res_q); m_final = 1;
          end else begin
            m_cur = m_cur + 1; m_tgt = m_cur;
          end
          e_win = 1; m_step = 1; m_mode = 2;
        end
      endcase
    end
    e_rdy = (m_mode == 3) ? 1 : 0;
    armed = 1;
    cyc++;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      chk("R2 tap_en", int'(tap_en_o), e_en);
      chk("R4 chg_win", int'(chg_win_o), e_win);
      chk("R3 tap_sel", int'(tap_sel_o), e_sel);
      chk("R7 done", int'(done_o), e_done);
      chk("R8 ready", int'(res_ready_o), e_rdy);
    end
  end

  task automatic sweep(logic [31:0] pat, int exp_final, int slow, bit poke_start, string tag);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < NT; i++) begin
      while (!res_ready_o) @(negedge clk);
      for (int d = 0; d < ((i % 4) * slow); d++) begin
        if (poke_start && d == 0) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
      chk({tag, " R3 tap order"}, int'(tap_sel_o), i);
      res_valid_i = 1'b1; res_pass_i = pat[i];
      @(negedge clk);
      res_valid_i = 1'b0; res_pass_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk({tag, " R6 final tap"}, int'(tap_sel_o), exp_final);
    chk({tag, " R2 enable kept"}, int'(tap_en_o), 1);
    @(negedge clk);
    chk({tag, " R7 done single"}, int'(done_o), 0);
    repeat (3) @(negedge clk);
    chk({tag, " R9 stays idle"}, int'(chg_win_o | res_ready_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outs", int'({tap_en_o, chg_win_o, res_ready_o, done_o}), 0);
    chk("R1 reset tap", int'(tap_sel_o), 0);
    rst_n = 1'b1;
    sweep(32'hFFFF_FFFF, 16, 0, 0, "all-pass R5");
    sweep(32'hFFFF_FC00, 21, 1, 0, "low-fail R5");
    sweep(32'hFC00_003F, 0, 0, 1, "wrap R6 R9");
    sweep(32'h0000_0000, 0, 2, 0, "all-fail R6");
    sweep(32'hF000_0003, 31, 1, 0, "wrap-high R6");
    sweep(32'hFFF0_0038, 27, 3, 1, "two-windows R5 R8");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule